// File: doc/BRIEF.md
# Byte-to-NRZ Serializer with Transmit-Ready Status

The block converts parallel bytes into a differential NRZ bit stream. It runs on the serial bit clock and sends one bit per cycle, so one byte takes eight cycles. A divide-by-eight parallel clock goes out to the upstream controller. The controller presents the next byte on that clock's rising edge, and the block samples it at the next byte boundary. Bytes follow each other with no idle cycle between them.

A transmit-ready output combines the following conditions:

- the block is out of reset;
- the block is not in sleep;
- the clock synthesizer reports lock;
- when the external parallel clock is selected, that clock is toggling.

Activity on the external clock is checked by an idle counter that runs on the serial clock. During reset and during sleep, the serial pair and the parallel clock are held at fixed levels. When either state ends, transmission restarts cleanly on a fresh byte.

Top module: `nrz_byte_serializer`

## Requirements
- R1: Each byte goes out most significant bit first, one bit per serial clock: bit 7 first, then bit 6 down to bit 0.
- R2: Consecutive bytes follow with no gap. The byte on `data_i` is sampled on the serial clock edge that ends bit 0 of the current byte, and its bit 7 appears in the next cycle.
- R3: `pclk_o` has a period of eight serial clocks. It is high during bit slots 7 to 4 of each byte and low during slots 3 to 0, so it rises in the cycle that a byte's bit 7 appears.
- R4: While `rst_ni` is low, `rdy_o`, `pclk_o` and `ser_p_o` are low and `ser_n_o` is high, independent of the clock.
- R5: While `sleep_i` is 1 and `rst_ni` is high, `rdy_o` and `ser_p_o` are low and `ser_n_o` and `pclk_o` are high. If both are active, the reset levels apply.
- R6: After reset is released or sleep ends, the first clock edge loads a fresh byte, and its bit 7 appears in the following cycle. Until that edge, the outputs keep `ser_p_o`=0, `ser_n_o`=1 and `pclk_o`=0. No part of a byte interrupted by reset or sleep is ever sent.
- R7: Outside reset and sleep, `ser_n_o` is always the inverse of `ser_p_o`.
- R8: `rdy_o` is 1 only when `rst_ni` is 1, `sleep_i` is 0, `lock_i` is 1 and the parallel clock condition of R9/R10 holds.
- R9: With `pclk_sel_i`=0 (external clock), the external clock counts as present once an edge has been detected. It counts as absent once 32 serial clocks pass with no detected edge, and it is absent from reset until the first edge. Ready follows this status within a few cycles of synchronizer delay.
- R10: With `pclk_sel_i`=1 (synthesized clock), activity on `ext_pclk_i` has no effect on `rdy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Parallel byte to transmit |
| ext_pclk_i | input | 1 | External parallel clock, monitored for activity |
| pclk_sel_i | input | 1 | 1 = synthesized clock, 0 = external clock |
| lock_i | input | 1 | Synthesizer PLL lock indication |
| sleep_i | input | 1 | Sleep request, active high |
| ser_p_o | output | 1 | Serial NRZ data, true |
| ser_n_o | output | 1 | Serial NRZ data, complement |
| pclk_o | output | 1 | Parallel clock output, serial clock / 8 |
| rdy_o | output | 1 | Transmit-ready status |

## Verification
The load assertion assumes that `data_i` is held stable across the edge that ends a byte. The bench satisfies this by changing `data_i` only on a falling clock edge, right after it sees `pclk_o` rise. The activity assertions assume that `ext_pclk_i` is a slow, level-type signal that a two-flop synchronizer can sample. The bench toggles it on falling edges once every four serial clocks, well inside the 32-cycle idle window. `sleep_i`, `lock_i` and `pclk_sel_i` are treated as quasi-static levels and are changed only away from the rising edge.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int unsigned BYTE_W_DEF   = 8;
  localparam int unsigned IDLE_LIM_DEF = 32;
endpackage

// File: rtl/nbs_shifter.sv
module nbs_shifter #(
  parameter int unsigned BYTE_W = nbs_pkg::BYTE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              bit_o,
  output logic              pclk_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(BYTE_W / 2);

  logic              run_q;
  logic [CNT_W-1:0]  idx_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              load_w;

  assign load_w = !run_q || (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '0;
    end else if (sleep_i) begin
      run_q   <= 1'b0;
      idx_q   <= '0;
    end else if (load_w) begin
      run_q   <= 1'b1;
      idx_q   <= '0;
      shreg_q <= data_i;
    end else begin
      idx_q   <= idx_q + 1'b1;
      shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign bit_o  = run_q & shreg_q[BYTE_W-1];
  assign pclk_o = run_q & (idx_q < HALF_IDX);

  AST_GAPLESS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && idx_q == LAST_IDX && !sleep_i) |=> (idx_q == '0 && shreg_q == $past(data_i))); // R2

  AST_MSB_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && idx_q != LAST_IDX && !sleep_i) |=> (shreg_q[BYTE_W-1] == $past(shreg_q[BYTE_W-2]))); // R1

  AST_START_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (idx_q == '0)); // R6

  AST_PCLK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_o) |-> (idx_q == '0)); // R3
endmodule

// File: rtl/nbs_act_mon.sv
module nbs_act_mon #(
  parameter int unsigned IDLE_LIM = nbs_pkg::IDLE_LIM_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_pclk_i,
  output logic alive_o
);
  localparam int unsigned WD_W = $clog2(IDLE_LIM + 1);
  localparam logic [WD_W-1:0] LIM = WD_W'(IDLE_LIM);

  logic [2:0]      sync_q;
  logic [WD_W-1:0] cnt_q;
  logic            edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_pclk_i};
  end

  assign edge_w = sync_q[2] ^ sync_q[1];

  // Counts serial clocks since the last edge; saturates at the limit (absent)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= LIM;
    else if (edge_w)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign alive_o = (cnt_q != LIM);

  AST_IDLE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R9

  AST_EDGE_REVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> alive_o); // R9

  AST_DROP_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alive_o) |-> ($past(cnt_q) == LIM - 1'b1 && !$past(edge_w))); // R9
endmodule

// File: rtl/nrz_byte_serializer.sv
module nrz_byte_serializer #(
  parameter int unsigned BYTE_W   = nbs_pkg::BYTE_W_DEF,
  parameter int unsigned IDLE_LIM = nbs_pkg::IDLE_LIM_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ext_pclk_i,
  input  logic              pclk_sel_i,
  input  logic              lock_i,
  input  logic              sleep_i,
  output logic              ser_p_o,
  output logic              ser_n_o,
  output logic              pclk_o,
  output logic              rdy_o
);
  logic bit_w, pclk_w, alive_w;

  nbs_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sleep_i(sleep_i),
    .data_i (data_i),
    .bit_o  (bit_w),
    .pclk_o (pclk_w)
  );

  nbs_act_mon #(.IDLE_LIM(IDLE_LIM)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_pclk_i(ext_pclk_i),
    .alive_o   (alive_w)
  );

  // Reset levels come from the shifter's async reset; sleep overrides here, reset wins on pclk
  assign ser_p_o = !sleep_i & bit_w;
  assign ser_n_o = sleep_i | !bit_w;
  assign pclk_o  = rst_ni & (sleep_i | pclk_w);
  assign rdy_o   = rst_ni & !sleep_i & lock_i & (pclk_sel_i | alive_w);

  AST_PAIR_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> (ser_n_o != ser_p_o)); // R7

  AST_SLEEP_EXIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i) && !sleep_i |-> (!ser_p_o && !pclk_o)); // R6
endmodule

// File: tb/nrz_byte_serializer_test.sv
module nrz_byte_serializer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       ext_pclk_i = 1'b0;
  logic       pclk_sel_i = 1'b1;
  logic       lock_i = 1'b1;
  logic       sleep_i = 1'b0;
  logic       ser_p_o, ser_n_o, pclk_o, rdy_o;
  logic       ext_run = 1'b0;
  logic       done = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  nrz_byte_serializer uut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .ext_pclk_i(ext_pclk_i),
    .pclk_sel_i(pclk_sel_i), .lock_i(lock_i), .sleep_i(sleep_i),
    .ser_p_o(ser_p_o), .ser_n_o(ser_n_o), .pclk_o(pclk_o), .rdy_o(rdy_o)
  );

  initial begin : ext_gen
    forever begin
      repeat (4) @(negedge clk);
      if (ext_run) ext_pclk_i = ~ext_pclk_i;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // Expects pclk_o rise and bit 7 at the current negedge; receives 8 bits
  task automatic rx_byte(input logic [7:0] exp, input logic [7:0] next, input string tag);
    logic [7:0] got;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      got[7-i] = ser_p_o;
      chk("R7 pair", {31'd0, ser_n_o}, {31'd0, ~ser_p_o});
      chk("R3 pclk shape", {31'd0, pclk_o}, {31'd0, (i < 4)});
      if (i == 0) data_i = next;
    end
    chk({"R1 byte ", tag}, {24'd0, got}, {24'd0, exp});
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; lock_i = 1'b1; pclk_sel_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 rdy", {31'd0, rdy_o}, 32'd0);
    chk("R4 pclk", {31'd0, pclk_o}, 32'd0);
    chk("R4 ser_p", {31'd0, ser_p_o}, 32'd0);
    chk("R4 ser_n", {31'd0, ser_n_o}, 32'd1);
  endtask

  task automatic t_stream();
    logic [7:0] pat [5] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81};
    data_i = pat[0];
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R6 idle before first load pclk", {31'd0, pclk_o}, 32'd0);
    chk("R6 idle before first load ser_n", {31'd0, ser_n_o}, 32'd1);
    @(negedge clk);
    chk("R6 first byte start", {31'd0, pclk_o}, 32'd1);
    for (int b = 0; b < 5; b++) begin
      if (b > 0) begin
        @(negedge clk);
        chk("R2 gapless boundary", {31'd0, pclk_o}, 32'd1);
      end
      rx_byte(pat[b], (b < 4) ? pat[b+1] : 8'h5A, "stream");
    end
    chk("R8 ready sync mode", {31'd0, rdy_o}, 32'd1);
  endtask

  task automatic t_sleep();
    repeat (3) @(negedge clk);
    sleep_i = 1'b1;
    #1;
    chk("R5 rdy", {31'd0, rdy_o}, 32'd0);
    chk("R5 ser_p", {31'd0, ser_p_o}, 32'd0);
    chk("R5 ser_n", {31'd0, ser_n_o}, 32'd1);
    chk("R5 pclk", {31'd0, pclk_o}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R5 pclk held", {31'd0, pclk_o}, 32'd1);
    data_i = 8'hC3;
    sleep_i = 1'b0;
    #1;
    chk("R6 exit idle pclk", {31'd0, pclk_o}, 32'd0);
    chk("R6 exit idle ser_p", {31'd0, ser_p_o}, 32'd0);
    @(negedge clk);
    chk("R6 fresh byte start", {31'd0, pclk_o}, 32'd1);
    rx_byte(8'hC3, 8'h96, "after sleep");
    @(negedge clk);
    rx_byte(8'h96, 8'h00, "after sleep 2");
    sleep_i = 1'b1;
    rst_ni = 1'b0;
    #1;
    chk("R5 reset wins pclk", {31'd0, pclk_o}, 32'd0);
    chk("R5 reset wins rdy", {31'd0, rdy_o}, 32'd0);
    @(negedge clk);
    sleep_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_ready();
    lock_i = 1'b0;
    #1;
    chk("R8 no lock", {31'd0, rdy_o}, 32'd0);
    lock_i = 1'b1;
    #1;
    chk("R8 lock sync", {31'd0, rdy_o}, 32'd1);
    pclk_sel_i = 1'b0;
    #1;
    chk("R9 absent after reset", {31'd0, rdy_o}, 32'd0);
    ext_run = 1'b1;
    repeat (12) @(negedge clk);
    chk("R9 present", {31'd0, rdy_o}, 32'd1);
    repeat (40) @(negedge clk);
    chk("R9 stays present", {31'd0, rdy_o}, 32'd1);
    ext_run = 1'b0;
    repeat (25) @(negedge clk);
    chk("R9 within window", {31'd0, rdy_o}, 32'd1);
    repeat (20) @(negedge clk);
    chk("R9 absent after window", {31'd0, rdy_o}, 32'd0);
    pclk_sel_i = 1'b1;
    #1;
    chk("R10 idle ext ignored", {31'd0, rdy_o}, 32'd1);
    ext_run = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 active ext ignored", {31'd0, rdy_o}, 32'd1);
    ext_run = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_stream();
    t_sleep();
    t_ready();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule